// File: doc/BRIEF.md
# Cartridge Clock Counter with Latched Snapshot

This block keeps a running time-of-day count for a game cartridge. It holds seconds, minutes, hours and a 9-bit day count, and advances once per pulse of a 1 Hz tick enable. The CPU cannot read the running count directly. It first writes 0 and then 1 to a latch region, which copies the running count into a snapshot. It then reads one snapshot byte at a time through a data window. A select region chooses which byte the window shows. The same region can instead hand the window to an external RAM bank, and the block drives that bank number out.

The CPU address is reduced to its three top bits, the region, before it reaches the block. The regions are: 0 for access enable, 2 for select, 3 for latch, and 5 for the data window (0xA000 to 0xBFFF). Writes to the data window in clock mode load the running counter fields directly. Reads return the selected snapshot byte one cycle after the request.

Top module: `cart_clock_top`

## Requirements
- R1: After reset, all running fields, all snapshot fields, the overflow flag and the latch state are zero. Access is disabled, RAM mode is selected with bank 0, and rd_data is 0xFF.
- R2: Each tick with no load in the same cycle adds one to the seconds. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day count.
- R3: The day count is 9 bits. Clock register 3 reads its low 8 bits. Clock register 4 reads bit 8 in bit 0 and the overflow flag in bit 7, and reads zero in bits 6:1. A carry out of day 511 sets the day count to 0 and sets the overflow flag. The flag then stays set until register 4 is written.
- R4: A write to region 2 with value 0x00 to 0x03 sets ram_bank to that value and leaves clock mode. A value of 0x08 to 0x0C selects clock register 0 to 4 (seconds, minutes, hours, day low, day high/flags) and enters clock mode. Any other value changes nothing.
- R5: Writing 0x01 to region 3 while not latched copies the running time into the snapshot and sets the latched state. Writing 0x00 while latched clears the latched state. A second 0x01 with no 0x00 in between, or time advancing, leaves the snapshot unchanged.
- R6: Writing 0x0A to region 0 enables access and writing 0x00 disables it. Other values have no effect.
- R7: In the cycle after rd_en with region 5, rd_data shows the selected snapshot byte if access is enabled and clock mode is set. Otherwise it shows 0xFF.
- R8: A write to region 5 with access enabled and clock mode set loads the selected running field. Seconds take bits 5:0, minutes bits 5:0, hours bits 4:0, and day low all 8 bits. Register 4 takes day bit 8 from bit 0 and the overflow flag from bit 7. Such a load takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second |
| addr_region | input | 3 | CPU address bits 15:13 |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 8 | Registered read data |
| ram_bank | output | 2 | Selected external RAM bank |

## Verification
The bench loads every field one step below its wrap point and ticks once. A design with a broken carry chain would show a non-zero field, or a day count with no overflow flag. It checks that the flag survives later ticks and relatches, and that writing register 4 clears it. A design that treats the latch as level-triggered would update the snapshot on a repeated 0x01 or as time runs. One that ignores mode would return clock data in RAM mode. A tick in the same cycle as a load is also driven, which exposes a design that lets the increment override the loaded value.

// File: rtl/cart_clock_pkg.sv
package cart_clock_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 9;
  localparam int SEC_MOD = 60;
  localparam int MIN_MOD = 60;
  localparam int HR_MOD  = 24;
  localparam int SEL_W = 3;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic             ovf;
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sec;
  } clk_time_t;

  function automatic logic [BYTE_W-1:0] pick_byte(clk_time_t t, logic [SEL_W-1:0] sel);
    logic [BYTE_W-1:0] b;
    b = '1;
    case (sel)
      3'd0: b = BYTE_W'(t.sec);
      3'd1: b = BYTE_W'(t.mn);
      3'd2: b = BYTE_W'(t.hr);
      3'd3: b = t.day[BYTE_W-1:0];
      3'd4: b = {t.ovf, 6'd0, t.day[DAY_W-1]};
      default: b = '1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/cart_clock_counter.sv
module cart_clock_counter
  import cart_clock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [BYTE_W-1:0] ld_data,
  output clk_time_t         now
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_MOD - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_MOD - 1);
  localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(HR_MOD - 1);

  logic sec_wrap, mn_wrap, hr_wrap, day_wrap;
  clk_time_t nxt;

  always_comb begin
    sec_wrap = now.sec >= SEC_LAST;
    mn_wrap  = now.mn  >= MIN_LAST;
    hr_wrap  = now.hr  >= HR_LAST;
    day_wrap = &now.day;
    nxt = now;
    nxt.sec = sec_wrap ? '0 : now.sec + 1'b1;
    if (sec_wrap) begin
      nxt.mn = mn_wrap ? '0 : now.mn + 1'b1;
      if (mn_wrap) begin
        nxt.hr = hr_wrap ? '0 : now.hr + 1'b1;
        if (hr_wrap) begin
          nxt.day = now.day + 1'b1;
          if (day_wrap) nxt.ovf = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '0;
    end else if (ld_en) begin
      case (ld_sel)
        3'd0: now.sec <= ld_data[SEC_W-1:0];
        3'd1: now.mn  <= ld_data[MIN_W-1:0];
        3'd2: now.hr  <= ld_data[HR_W-1:0];
        3'd3: now.day[BYTE_W-1:0] <= ld_data;
        3'd4: begin
          now.day[DAY_W-1] <= ld_data[0];
          now.ovf          <= ld_data[BYTE_W-1];
        end
        default: ;
      endcase
    end else if (tick) begin
      now <= nxt;
    end
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && now.sec == SEC_LAST) |=> (now.sec == '0)); // R2

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (now.ovf && !(ld_en && ld_sel == 3'd4)) |=> now.ovf); // R3

  AST_DAY_ROLL: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && now.sec == SEC_LAST && now.mn == MIN_LAST &&
     now.hr == HR_LAST && (&now.day)) |=> (now.day == '0 && now.ovf)); // R3
endmodule

// File: rtl/cart_clock_ctrl.sv
module cart_clock_ctrl
  import cart_clock_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        region,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              acc_en,
  output logic              clk_mode,
  output logic [SEL_W-1:0]  sel,
  output logic [BANK_W-1:0] ram_bank,
  output logic              cap
);
  localparam logic [2:0] RG_EN    = 3'd0;
  localparam logic [2:0] RG_SEL   = 3'd2;
  localparam logic [2:0] RG_LATCH = 3'd3;
  localparam logic [BYTE_W-1:0] BANK_LIM = BYTE_W'(1 << BANK_W);

  logic latched;
  logic wr_en_rg, wr_sel_rg, wr_latch_rg;

  assign wr_en_rg    = wr_en && region == RG_EN;
  assign wr_sel_rg   = wr_en && region == RG_SEL;
  assign wr_latch_rg = wr_en && region == RG_LATCH;
  assign cap = wr_latch_rg && !latched && wr_data == 8'h01;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_en   <= 1'b0;
      clk_mode <= 1'b0;
      sel      <= '0;
      ram_bank <= '0;
      latched  <= 1'b0;
    end else begin
      if (wr_en_rg) begin
        if (wr_data == 8'h0A)      acc_en <= 1'b1;
        else if (wr_data == 8'h00) acc_en <= 1'b0;
      end
      if (wr_sel_rg) begin
        if (wr_data < BANK_LIM) begin
          ram_bank <= wr_data[BANK_W-1:0];
          clk_mode <= 1'b0;
        end else if (wr_data >= 8'h08 && wr_data <= 8'h0C) begin
          sel      <= SEL_W'(wr_data - 8'h08);
          clk_mode <= 1'b1;
        end
      end
      if (cap) latched <= 1'b1;
      else if (wr_latch_rg && latched && wr_data == 8'h00) latched <= 1'b0;
    end
  end

  AST_MODE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_mode) |-> $past(wr_en && region == RG_SEL &&
                              wr_data >= 8'h08 && wr_data <= 8'h0C)); // R4

  AST_NO_DOUBLE_CAP: assert property (@(posedge clk) disable iff (rst)
    cap |=> !(wr_latch_rg && wr_data == 8'h01 && cap)); // R5
endmodule

// File: rtl/cart_clock_snap.sv
module cart_clock_snap
  import cart_clock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  clk_time_t         now,
  input  logic [SEL_W-1:0]  sel,
  output logic [BYTE_W-1:0] snap_byte
);
  clk_time_t snap_q;

  always_ff @(posedge clk) begin
    if (rst)      snap_q <= '0;
    else if (cap) snap_q <= now;
  end

  assign snap_byte = pick_byte(snap_q, sel);

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(snap_q)); // R5
endmodule

// File: rtl/cart_clock_top.sv
module cart_clock_top
  import cart_clock_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [2:0]        addr_region,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic [BANK_W-1:0] ram_bank
);
  localparam logic [2:0] RG_WIN = 3'd5;

  logic             acc_en, clk_mode, cap, win_open, ld_en;
  logic [SEL_W-1:0] sel;
  logic [7:0]       snap_byte;
  clk_time_t        now;

  cart_clock_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .region(addr_region),
    .wr_data(wr_data), .acc_en(acc_en), .clk_mode(clk_mode),
    .sel(sel), .ram_bank(ram_bank), .cap(cap)
  );

  assign win_open = addr_region == RG_WIN && acc_en && clk_mode;
  assign ld_en    = wr_en && win_open;

  cart_clock_counter u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .ld_en(ld_en),
    .ld_sel(sel), .ld_data(wr_data), .now(now)
  );

  cart_clock_snap u_snap (
    .clk(clk), .rst(rst), .cap(cap), .now(now),
    .sel(sel), .snap_byte(snap_byte)
  );

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'hFF;
    else if (rd_en) rd_data <= win_open ? snap_byte : 8'hFF;
  end

  AST_RD_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !acc_en) |=> (rd_data == 8'hFF)); // R7
endmodule

// File: tb/test_cart_clock_top.sv
module test_cart_clock_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [2:0] addr_region = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] ram_bank;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cart_clock_top i_cart_clock_top (
    .clk(clk), .rst(rst), .tick(tick), .addr_region(addr_region),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .ram_bank(ram_bank)
  );

  // row = {op[1:0], region[2:0], data[7:0], expect[7:0], req[3:0]}
  // op: 0 write, 1 read and compare, 2 tick
  localparam int NV = 26;
  localparam logic [24:0] VEC [NV] = '{
    {2'd1, 3'd5, 8'h00, 8'hFF, 4'd7},  // R7 closed
    {2'd0, 3'd0, 8'h0A, 8'h00, 4'd6},
    {2'd0, 3'd2, 8'h08, 8'h00, 4'd4},
    {2'd1, 3'd5, 8'h00, 8'h00, 4'd1},  // R1
    {2'd2, 3'd0, 8'h00, 8'h00, 4'd2},
    {2'd2, 3'd0, 8'h00, 8'h00, 4'd2},
    {2'd2, 3'd0, 8'h00, 8'h00, 4'd2},
    {2'd1, 3'd5, 8'h00, 8'h00, 4'd5},  // R5 not latched yet
    {2'd0, 3'd3, 8'h01, 8'h00, 4'd5},
    {2'd1, 3'd5, 8'h00, 8'h03, 4'd5},
    {2'd2, 3'd0, 8'h00, 8'h00, 4'd2},
    {2'd0, 3'd3, 8'h01, 8'h00, 4'd5},
    {2'd1, 3'd5, 8'h00, 8'h03, 4'd5},  // R5 repeat 1 ignored
    {2'd0, 3'd3, 8'h00, 8'h00, 4'd5},
    {2'd0, 3'd3, 8'h01, 8'h00, 4'd5},
    {2'd1, 3'd5, 8'h00, 8'h04, 4'd5},
    {2'd0, 3'd2, 8'h02, 8'h00, 4'd4},
    {2'd1, 3'd5, 8'h00, 8'hFF, 4'd4},  // R4 RAM mode
    {2'd0, 3'd2, 8'h0D, 8'h00, 4'd4},
    {2'd1, 3'd5, 8'h00, 8'hFF, 4'd4},
    {2'd0, 3'd2, 8'h0A, 8'h00, 4'd4},
    {2'd1, 3'd5, 8'h00, 8'h00, 4'd4},
    {2'd0, 3'd0, 8'h05, 8'h00, 4'd6},
    {2'd1, 3'd5, 8'h00, 8'h00, 4'd6},  // R6 other value ignored
    {2'd0, 3'd0, 8'h00, 8'h00, 4'd6},
    {2'd1, 3'd5, 8'h00, 8'hFF, 4'd6}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] rg, input logic [7:0] d);
    addr_region = rg; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] rg, input logic [7:0] exp, input string req);
    addr_region = rg; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data, exp, req);
  endtask

  task automatic pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic relatch();
    wr(3'd3, 8'h00);
    wr(3'd3, 8'h01);
  endtask

  task automatic rd_reg(input logic [7:0] selv, input logic [7:0] exp, input string req);
    wr(3'd2, selv);
    rd(3'd5, exp, req);
  endtask

  task automatic ld_reg(input logic [7:0] selv, input logic [7:0] d);
    wr(3'd2, selv);
    wr(3'd5, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_data, 8'hFF, "R1 rd_data");
    check({6'd0, ram_bank}, 8'h00, "R1 ram_bank");

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [2:0] rg;
      logic [7:0] d, e;
      logic [3:0] rq;
      {op, rg, d, e, rq} = VEC[i];
      case (op)
        2'd0: wr(rg, d);
        2'd1: rd(rg, e, $sformatf("R%0d vec %0d", rq, i));
        default: pulse();
      endcase
    end

    wr(3'd0, 8'h0A);
    wr(3'd2, 8'h03);
    check({6'd0, ram_bank}, 8'h03, "R4 ram_bank");

    // full carry chain to day overflow
    ld_reg(8'h08, 8'h3B);
    ld_reg(8'h09, 8'h3B);
    ld_reg(8'h0A, 8'h17);
    ld_reg(8'h0B, 8'hFF);
    ld_reg(8'h0C, 8'h01);
    pulse();
    relatch();
    rd_reg(8'h0C, 8'h80, "R3 overflow flag");
    rd_reg(8'h0B, 8'h00, "R3 day low");
    rd_reg(8'h08, 8'h00, "R2 sec wrap");
    rd_reg(8'h09, 8'h00, "R2 min wrap");
    rd_reg(8'h0A, 8'h00, "R2 hour wrap");

    pulse();
    pulse();
    relatch();
    rd_reg(8'h0C, 8'h80, "R3 flag sticky");
    rd_reg(8'h08, 8'h02, "R2 sec count");

    // load beats tick in the same cycle
    wr(3'd2, 8'h08);
    addr_region = 3'd5; wr_data = 8'h0A; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    relatch();
    rd(3'd5, 8'h0A, "R8 load over tick");

    ld_reg(8'h0C, 8'h01);
    relatch();
    rd(3'd5, 8'h01, "R8 reg4 write clears flag");

    ld_reg(8'h08, 8'h3B);
    ld_reg(8'h09, 8'h05);
    pulse();
    relatch();
    rd_reg(8'h09, 8'h06, "R2 min carry");
    rd_reg(8'h08, 8'h00, "R2 sec carry");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule